// File: doc/BRIEF.md
# Packed Unsigned Lane Add/Subtract Unit

This unit performs lane-parallel unsigned arithmetic on two 32-bit operands. It has two lane layouts. One splits each operand into two 16-bit halfwords, and the other splits it into four 8-bit bytes. Each lane adds or subtracts without affecting its neighbours. Each lane reports a greater-or-equal flag: the carry-out for an addition, or the absence of a borrow for a subtraction. Two halfword forms swap the halves of the second operand before the lanes combine. One of them subtracts in the low lane and adds in the high lane; the other does the reverse.

The unit sits in an execute stage. A valid strobe presents an operation, a 4-bit condition code and the current NZCV flags. If the condition holds, the result, the four GE bits and the destination index are registered one cycle later, together with an output strobe. If the condition fails, or the operation code is reserved, the registered state stays unchanged. A reserved code also raises a one-cycle undefined-operation pulse.

Top module: `simd_addsub_unit`

## Requirements
- R1: Operation code 0 adds the low halfwords and the high halfwords separately; each halfword's GE pair is 1 exactly when that unsigned sum exceeds 16'hFFFF.
- R2: Operation code 3 subtracts the halfwords of b from those of a separately; each halfword's GE pair is 1 exactly when a's halfword is greater than or equal to b's.
- R3: Operation code 1 gives a low lane of a[15:0] − b[31:16], with GE[1:0] = no-borrow. It gives a high lane of a[31:16] + b[15:0], with GE[3:2] = carry-out.
- R4: Operation code 2 gives a low lane of a[15:0] + b[31:16], with GE[1:0] = carry-out. It gives a high lane of a[31:16] − b[15:0], with GE[3:2] = no-borrow.
- R5: Operation code 4 adds the four bytes separately; GE[i] is the carry-out of byte lane i, where byte i is bits 8i+7:8i.
- R6: Operation code 7 subtracts the four bytes separately; GE[i] is 1 when byte i of a is greater than or equal to byte i of b.
- R7: Each lane of the result keeps only the low 8 or 16 bits of its sum or difference, in that lane's own bit position, and no carry crosses into the next lane.
- R8: For every halfword operation, GE[1] equals GE[0] and GE[3] equals GE[2].
- R9: The flags input is ordered N=bit 3, Z=bit 2, C=bit 1, V=bit 0. Condition code 4'hE always executes and 4'hF never executes. Codes 0 to 13 execute when EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT and LE hold, in that order. A failed condition leaves result, GE and destination unchanged and keeps the output strobe low.
- R10: Operation codes 5 and 6 are reserved. One cycle after they are issued, the undefined-operation output pulses high for one cycle, the output strobe stays low, and result, GE and destination keep their values.
- R11: An executed operation updates result, GE and destination on the clock edge that samples it. The output strobe is high for that one cycle only.
- R12: After reset, the result, GE, destination, output strobe and undefined outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation presented this cycle |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | NZCV flags {N,Z,C,V} |
| op_i | input | 3 | Operation code |
| dst_i | input | 4 | Destination register index |
| opa_i | input | 32 | First operand (minuend / augend) |
| opb_i | input | 32 | Second operand |
| result_o | output | 32 | Registered packed result |
| ge_o | output | 4 | Registered per-lane GE flags |
| dst_o | output | 4 | Destination index of the last executed operation |
| valid_o | output | 1 | One-cycle strobe: outputs were just written |
| undef_o | output | 1 | One-cycle strobe: a reserved operation was issued |

## Verification
The hardest case to reach is a pass or fail decided by a compound condition such as HI, GT or LE on a flag pattern where the simple reading and the correct reading disagree. Examples are C set with Z set, or N differing from V while Z is clear. The stimulus runs every one of the sixteen condition codes against a fixed set of NZCV patterns chosen to split these cases. After each issue it checks whether the state was updated or held against the previous value. Lane boundaries are reached with operands of all ones, equal operands and operands that differ by one.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_N = 2;
  localparam int unsigned BYTE_N = 4;
  localparam int unsigned HALF_W = DATA_W / HALF_N;
  localparam int unsigned BYTE_W = DATA_W / BYTE_N;
  localparam int unsigned GE_W   = BYTE_N;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'd0,
    OP_ASX   = 3'd1,
    OP_SAX   = 3'd2,
    OP_SUB16 = 3'd3,
    OP_ADD8  = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_SUB8  = 3'd7
  } lane_op_e;

  localparam logic [3:0] COND_ALWAYS = 4'hE;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ge_o
);
  logic [W:0] ext;

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
    else       ext = {1'b0, a_i} + {1'b0, b_i};
    res_o = ext[W-1:0];
    // add: carry out; sub: no borrow
    ge_o  = sub_i ? ~ext[W] : ext[W];
  end
endmodule

// File: rtl/simd_cond_eval.sv
module simd_cond_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] nzcv_i,
  output logic       pass_o
);
  logic n, z, c, v;

  always_comb begin
    {n, z, c, v} = nzcv_i;
    unique case (cond_i)
      4'h0: pass_o = z;
      4'h1: pass_o = ~z;
      4'h2: pass_o = c;
      4'h3: pass_o = ~c;
      4'h4: pass_o = n;
      4'h5: pass_o = ~n;
      4'h6: pass_o = v;
      4'h7: pass_o = ~v;
      4'h8: pass_o = c & ~z;
      4'h9: pass_o = ~c | z;
      4'hA: pass_o = (n == v);
      4'hB: pass_o = (n != v);
      4'hC: pass_o = ~z & (n == v);
      4'hD: pass_o = z | (n != v);
      4'hE: pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/simd_half_path.sv
module simd_half_path
  import simd_addsub_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] res_o,
  output logic [GE_W-1:0]   ge_o
);
  logic                         exch;
  logic [HALF_N-1:0]            sub;
  logic [HALF_N-1:0][HALF_W-1:0] a_h, b_h, r_h;
  logic [HALF_N-1:0]            g_h;

  always_comb begin
    exch   = (op_i == OP_ASX) || (op_i == OP_SAX);
    sub[0] = (op_i == OP_ASX) || (op_i == OP_SUB16);
    sub[1] = (op_i == OP_SAX) || (op_i == OP_SUB16);
    a_h    = a_i;
    b_h[0] = exch ? b_i[DATA_W-1:HALF_W] : b_i[HALF_W-1:0];
    b_h[1] = exch ? b_i[HALF_W-1:0]      : b_i[DATA_W-1:HALF_W];
  end

  for (genvar h = 0; h < HALF_N; h++) begin : g_lane
    simd_lane #(.W(HALF_W)) i_lane (
      .a_i  (a_h[h]),
      .b_i  (b_h[h]),
      .sub_i(sub[h]),
      .res_o(r_h[h]),
      .ge_o (g_h[h])
    );
    assign ge_o[2*h]   = g_h[h];
    assign ge_o[2*h+1] = g_h[h];
  end

  assign res_o = r_h;
endmodule

// File: rtl/simd_byte_path.sv
module simd_byte_path
  import simd_addsub_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] res_o,
  output logic [GE_W-1:0]   ge_o
);
  logic                          sub;
  logic [BYTE_N-1:0][BYTE_W-1:0] a_b, b_b, r_b;

  assign sub = (op_i == OP_SUB8);
  assign a_b = a_i;
  assign b_b = b_i;

  for (genvar i = 0; i < BYTE_N; i++) begin : g_lane
    simd_lane #(.W(BYTE_W)) i_lane (
      .a_i  (a_b[i]),
      .b_i  (b_b[i]),
      .sub_i(sub),
      .res_o(r_b[i]),
      .ge_o (ge_o[i])
    );
  end

  assign res_o = r_b;
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_addsub_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [2:0]        op_i,
  input  logic [3:0]        dst_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic [GE_W-1:0]   ge_o,
  output logic [3:0]        dst_o,
  output logic              valid_o,
  output logic              undef_o
);
  logic [DATA_W-1:0] half_res, byte_res, nxt_res;
  logic [GE_W-1:0]   half_ge, byte_ge, nxt_ge;
  logic              cond_ok, legal, fire;

  simd_cond_eval i_cond (
    .cond_i(cond_i),
    .nzcv_i(flags_i),
    .pass_o(cond_ok)
  );

  simd_half_path i_half (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .op_i (op_i),
    .res_o(half_res),
    .ge_o (half_ge)
  );

  simd_byte_path i_byte (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .op_i (op_i),
    .res_o(byte_res),
    .ge_o (byte_ge)
  );

  always_comb begin
    legal   = (op_i != OP_RSV5) && (op_i != OP_RSV6);
    fire    = valid_i && legal && cond_ok;
    nxt_res = op_i[2] ? byte_res : half_res;
    nxt_ge  = op_i[2] ? byte_ge  : half_ge;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ge_o     <= '0;
      dst_o    <= '0;
      valid_o  <= 1'b0;
      undef_o  <= 1'b0;
    end else begin
      valid_o <= fire;
      undef_o <= valid_i && !legal;
      if (fire) begin
        result_o <= nxt_res;
        ge_o     <= nxt_ge;
        dst_o    <= dst_i;
      end
    end
  end
endmodule

// File: rtl/simd_addsub_unit_chk.sv
module simd_addsub_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  cond_i,
  input logic [2:0]  op_i,
  input logic [31:0] result_o,
  input logic [3:0]  ge_o,
  input logic [3:0]  dst_o,
  input logic        valid_o,
  input logic        undef_o
);
  assert_halfword_ge_pairs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(op_i[2])) |-> (ge_o[1] == ge_o[0] && ge_o[3] == ge_o[2]));

  assert_always_code_fires_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'hE && op_i != 3'd5 && op_i != 3'd6) |=> valid_o);

  assert_never_code_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'hF) |=> !valid_o);

  assert_reserved_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd5 || op_i == 3'd6)) |=>
      (undef_o && !valid_o && $stable(result_o) && $stable(ge_o) && $stable(dst_o)));

  assert_strobes_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && undef_o));

  assert_idle_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(ge_o) && $stable(dst_o)));

  assert_strobe_needs_issue_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

bind simd_addsub_unit simd_addsub_unit_chk i_chk (.*);

// File: tb/test_simd_addsub_unit.sv
module test_simd_addsub_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  cond_i = 4'hE;
  logic [3:0]  flags_i = 4'h0;
  logic [2:0]  op_i = 3'd0;
  logic [3:0]  dst_i = 4'h0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [31:0] result_o;
  logic [3:0]  ge_o, dst_o;
  logic        valid_o, undef_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [31:0] exp_res = '0;
  logic [3:0]  exp_ge = '0, exp_dst = '0;
  logic        exp_valid = 0, exp_undef = 0;

  always #10 clk_i = ~clk_i;

  simd_addsub_unit i_simd_addsub_unit (.*);

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic bit cond_model(logic [3:0] c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z == 1;   1: return z == 0;
      2: return cy == 1;  3: return cy == 0;
      4: return n == 1;   5: return n == 0;
      6: return v == 1;   7: return v == 0;
      8: return (cy == 1) && (z == 0);
      9: return (cy == 0) || (z == 1);
      10: return n == v;  11: return n != v;
      12: return (z == 0) && (n == v);
      13: return (z == 1) || (n != v);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  // one lane of width w: add or subtract, returns {ge, result}
  function automatic logic [16:0] lane_model(int w, int a, int b, bit sub);
    int mask = (1 << w) - 1;
    int r;
    bit g;
    if (sub) begin r = a - b; g = (a >= b); end
    else     begin r = a + b; g = (a + b) > mask; end
    return {g, 16'(r & mask)};
  endfunction

  task automatic model(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       output logic [31:0] res, output logic [3:0] ge);
    logic [16:0] lo, hi;
    int al = int'(a[15:0]), ah = int'(a[31:16]), bl = int'(b[15:0]), bh = int'(b[31:16]);
    res = '0; ge = '0;
    case (op)
      3'd0: begin lo = lane_model(16, al, bl, 0); hi = lane_model(16, ah, bh, 0); end
      3'd3: begin lo = lane_model(16, al, bl, 1); hi = lane_model(16, ah, bh, 1); end
      3'd1: begin lo = lane_model(16, al, bh, 1); hi = lane_model(16, ah, bl, 0); end
      3'd2: begin lo = lane_model(16, al, bh, 0); hi = lane_model(16, ah, bl, 1); end
      default: begin lo = '0; hi = '0; end
    endcase
    if (op == 3'd4 || op == 3'd7) begin
      for (int i = 0; i < 4; i++) begin
        logic [16:0] t = lane_model(8, int'(a[8*i+:8]), int'(b[8*i+:8]), op == 3'd7);
        res[8*i+:8] = t[7:0];
        ge[i] = t[16];
      end
    end else begin
      res = {hi[15:0], lo[15:0]};
      ge  = {hi[16], hi[16], lo[16], lo[16]};
    end
  endtask

  task automatic run(string req, logic [3:0] c, logic [3:0] f, logic [2:0] op,
                     logic [3:0] d, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    logic [3:0] g;
    bit illegal = (op == 3'd5 || op == 3'd6);
    bit exec = !illegal && cond_model(c, f);
    model(op, a, b, r, g);
    @(negedge clk_i);
    valid_i = 1; cond_i = c; flags_i = f; op_i = op; dst_i = d; opa_i = a; opb_i = b;
    @(negedge clk_i);
    valid_i = 0;
    exp_valid = exec;
    exp_undef = illegal;
    if (exec) begin exp_res = r; exp_ge = g; exp_dst = d; end
    chk(req, "result", result_o, exp_res);
    chk(req, "ge", 32'(ge_o), 32'(exp_ge));
    chk(req, "dst", 32'(dst_o), 32'(exp_dst));
    chk(req, "valid_o", 32'(valid_o), 32'(exp_valid));
    chk(req, "undef_o", 32'(undef_o), 32'(exp_undef));
  endtask

  task automatic t_reset;  // R12
    chk("R12", "result", result_o, 0);
    chk("R12", "ge", 32'(ge_o), 0);
    chk("R12", "dst", 32'(dst_o), 0);
    chk("R12", "valid_o", 32'(valid_o), 0);
    chk("R12", "undef_o", 32'(undef_o), 0);
  endtask

  task automatic t_half_add;  // R1 R7 R8
    run("R1", 4'hE, 0, 3'd0, 4'd1, 32'h0001_FFFF, 32'h0002_0001);
    run("R1", 4'hE, 0, 3'd0, 4'd2, 32'hFFFF_1234, 32'hFFFF_0001);
    run("R7", 4'hE, 0, 3'd0, 4'd3, 32'h8000_8000, 32'h8000_7FFF);
    run("R8", 4'hE, 0, 3'd0, 4'd4, 32'h0000_0000, 32'h0000_0000);
  endtask

  task automatic t_half_sub;  // R2
    run("R2", 4'hE, 0, 3'd3, 4'd5, 32'h1234_0005, 32'h1234_0006);
    run("R2", 4'hE, 0, 3'd3, 4'd6, 32'h0000_FFFF, 32'h0001_0000);
    run("R2", 4'hE, 0, 3'd3, 4'd7, 32'hABCD_0100, 32'h0001_00FF);
  endtask

  task automatic t_exchange;  // R3 R4
    run("R3", 4'hE, 0, 3'd1, 4'd8, 32'h0001_0010, 32'hFFFF_0011);
    run("R3", 4'hE, 0, 3'd1, 4'd9, 32'hFFFF_0020, 32'h0010_0002);
    run("R4", 4'hE, 0, 3'd2, 4'd10, 32'h0005_FFF0, 32'h0006_0010);
    run("R4", 4'hE, 0, 3'd2, 4'd11, 32'h0007_0001, 32'h0007_0002);
  endtask

  task automatic t_bytes;  // R5 R6 R7 R8
    run("R5", 4'hE, 0, 3'd4, 4'd12, 32'hFF01_80FF, 32'h0101_8001);
    run("R5", 4'hE, 0, 3'd4, 4'd13, 32'h0000_FFFF, 32'h0000_00FF);
    run("R6", 4'hE, 0, 3'd7, 4'd14, 32'h0510_00FF, 32'h0511_0000);
    run("R6", 4'hE, 0, 3'd7, 4'd15, 32'h0001_7F80, 32'h0100_807F);
  endtask

  task automatic t_cond;  // R9
    logic [3:0] pats [8] = '{4'h0, 4'hF, 4'h4, 4'h2, 4'h6, 4'h9, 4'h8, 4'h1};
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 8; p++)
        run("R9", 4'(c), pats[p], 3'(c % 8 == 5 ? 0 : (c % 8 == 6 ? 4 : c % 8)),
            4'(c ^ p), 32'h1357_9BDF + 32'(c * 97 + p), 32'h2468_ACE0 ^ 32'(p * 131));
  endtask

  task automatic t_reserved;  // R10
    run("R10", 4'hE, 0, 3'd0, 4'd3, 32'h1111_2222, 32'h3333_4444);
    run("R10", 4'hE, 0, 3'd5, 4'd9, 32'hFFFF_FFFF, 32'h0000_0001);
    run("R10", 4'h0, 4'h4, 3'd6, 4'd9, 32'h00FF_00FF, 32'h0001_0001);
    @(negedge clk_i);
    chk("R10", "undef_o pulse end", 32'(undef_o), 0);
  endtask

  task automatic t_latency;  // R11
    run("R11", 4'hE, 0, 3'd4, 4'd6, 32'h0102_0304, 32'h1010_1010);
    @(negedge clk_i);
    chk("R11", "valid_o idle", 32'(valid_o), 0);
    chk("R11", "result held", result_o, exp_res);
    chk("R11", "dst held", 32'(dst_o), 32'(exp_dst));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #35;
    t_reset();
    rst_ni = 1;
    t_half_add();
    t_half_sub();
    t_exchange();
    t_bytes();
    t_reserved();
    t_latency();
    t_cond();
    finish_run();
  end
endmodule